// File: doc/BRIEF.md
# Soft-Start and Enable Sequencer

This block steps a buck controller from power-up to closed-loop regulation. It waits until the supply-good flag is high and the enable/compensation pin has risen past its turn-on threshold. It then waits for the pin to settle at its charge ceiling. After that it produces a stepped soft-start ramp. The error-amplifier reference is the smaller of this ramp and the fixed target. Once the ramp reaches the target it does not stop. It keeps climbing to a much higher top code, and only there does it report that soft-start has finished. That report arms undervoltage protection elsewhere.

During each start attempt the block checks the input supply once. The check is made on the first high-side pulse, when the switch node must be above 2 V. If it is not, switching stops for that attempt. The ramp still runs all the way to its top. A fixed hiccup wait follows, and then the ramp restarts from zero.

Losing supply-good or enable at any moment sends the block back to idle and clears the ramp. All inputs are digital comparator flags that are already synchronous to `clk`. The analog comparators are outside this block.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, `ramp_code`, `ref_code`, `pwm_run` and `ss_done` are all 0.
- R2: No ramp starts and `pwm_run` stays 0 until `por_ok` and `en_above` are both high and `comp_ceil` has then been seen high. With all three already high, the ramp starts two clock edges after the sequence leaves idle.
- R3: Once the ramp has started, `ramp_code` equals k*STEP_CODE exactly k*STEP_CYC clock edges later. STEP_CYC is CLK_KHZ*RAMP_US/100000, and never less than 1.
- R4: `ref_code` is the lower of `ramp_code` and REF_CODE. REF_CODE is 100*STEP_CODE, so the target is reached in exactly 100 steps.
- R5: The ramp keeps rising past REF_CODE and saturates at CEIL_CODE. If the supply check did not fail, `ss_done` goes high one edge after the ramp reaches CEIL_CODE and stays high.
- R6: `pwm_run` is high throughout the ramp while the supply check has not failed, and it is high while `ss_done` is high.
- R7: If `hs_first` is seen high while `sw_hi` is low, at the first strobe of an attempt, then `pwm_run` is 0 from the next edge. The ramp keeps counting.
- R8: After a failed supply check, the ramp holds at CEIL_CODE for HICCUP_CYC edges with `ss_done` and `pwm_run` low. HICCUP_CYC is CLK_KHZ*HICCUP_US/1000. The ramp then restarts from 0 with `pwm_run` high.
- R9: If `por_ok` or `en_above` is low at any edge, then after that edge `ramp_code` is 0, `pwm_run` is 0 and `ss_done` is 0.
- R10: `pullup_en` is high exactly when `por_ok` is high and `ss_done` is low.
- R11: Only the first `hs_first` strobe of an attempt is evaluated. A later strobe with `sw_hi` low has no effect on `pwm_run`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| por_ok | input | 1 | Supply above power-on threshold (hysteresis applied in analog) |
| en_above | input | 1 | Enable/compensation pin above turn-on threshold |
| comp_ceil | input | 1 | Enable/compensation pin at or above its charge ceiling |
| sw_hi | input | 1 | Switch node above 2 V |
| hs_first | input | 1 | One-cycle strobe marking a high-side pulse |
| ramp_code | output | CODE_W | Soft-start ramp code |
| ref_code | output | CODE_W | Selected reference code: the lower of ramp and target |
| pwm_run | output | 1 | Switching permitted |
| ss_done | output | 1 | Soft-start finished; arms undervoltage protection |
| pullup_en | output | 1 | Enables the pin charge current source |

## Verification
The hiccup retry is the hardest case to reach from the ports. To get there, a single high-side strobe must arrive during a ramp while the switch-node flag is low. The ramp must then run to its high top code, and the full hiccup wait must pass before the restart can be seen. The bench sets the clock and timing parameters so that one ramp step is five cycles and the hiccup is 200 cycles. It injects the failing strobe twenty edges into an attempt. It then samples at the edge where the ceiling is reached, inside the hiccup, and at the restart edge. In the following attempt it sends a passing strobe and then a failing one, to show that the second strobe is ignored.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_ARM    = 3'd1,
    SQ_RAMP   = 3'd2,
    SQ_HICCUP = 3'd3,
    SQ_DONE   = 3'd4
  } sq_state_e;

  // Clock cycles per interval, floored at one cycle.
  function automatic int cycles_for(input int clk_khz, input int time_us, input int divisor);
    int raw;
    raw = (clk_khz * time_us) / (1000 * divisor);
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/ss_step_timer.sv
// Free-running interval counter: emits a one-cycle tick every PERIOD cycles
// while run is high, and restarts from zero whenever run drops.
module ss_step_timer #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || (cnt_q == LAST)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/ss_ramp_gen.sv
// Saturating stepped ramp plus reference selection.
module ss_ramp_gen #(
  parameter int CODE_W    = 10,
  parameter int STEP_CODE = 1,
  parameter int CEIL_CODE = 525,
  parameter int REF_CODE  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  output logic [CODE_W-1:0] ramp_code,
  output logic [CODE_W-1:0] ref_code,
  output logic              at_ceil
);

  localparam logic [CODE_W:0]   STEP_W = (CODE_W+1)'(STEP_CODE);
  localparam logic [CODE_W:0]   CEIL_W = (CODE_W+1)'(CEIL_CODE);
  localparam logic [CODE_W-1:0] CEIL_C = CODE_W'(CEIL_CODE);
  localparam logic [CODE_W-1:0] REF_C  = CODE_W'(REF_CODE);

  logic [CODE_W-1:0] ramp_q;
  logic [CODE_W:0]   sum;
  logic [CODE_W-1:0] ramp_nxt;

  assign sum      = {1'b0, ramp_q} + STEP_W;
  assign ramp_nxt = (sum >= CEIL_W) ? CEIL_C : sum[CODE_W-1:0];
  assign at_ceil  = (ramp_q == CEIL_C);
  assign ramp_code = ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
    end else if (clr) begin
      ramp_q <= '0;
    end else if (tick && !at_ceil) begin
      ramp_q <= ramp_nxt;
    end
  end

  // If the ceiling never exceeds the target, the ramp is always the smaller.
  generate
    if (REF_CODE >= CEIL_CODE) begin : g_ref_pass
      assign ref_code = ramp_q;
    end else begin : g_ref_min
      assign ref_code = (ramp_q < REF_C) ? ramp_q : REF_C;
    end
  endgenerate

endmodule

// File: rtl/ss_vin_check.sv
// One-shot input-supply check taken on the first high-side strobe of an attempt.
module ss_vin_check (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic hs_strobe,
  input  logic sw_high,
  output logic absent
);

  logic checked_q;
  logic absent_q;

  assign absent = absent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      checked_q <= 1'b0;
      absent_q  <= 1'b0;
    end else if (clr) begin
      checked_q <= 1'b0;
      absent_q  <= 1'b0;
    end else if (arm && hs_strobe && !checked_q) begin
      checked_q <= 1'b1;
      absent_q  <= !sw_high;
    end
  end

endmodule

// File: rtl/ss_ctrl_fsm.sv
// Sequencing state machine: idle, armed, ramping, hiccup wait, done.
module ss_ctrl_fsm
  import ss_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort,
  input  logic      comp_ceil,
  input  logic      at_ceil,
  input  logic      vin_absent,
  input  logic      hic_tick,
  output sq_state_e st_q
);

  sq_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (abort) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE:   st_d = SQ_ARM;
        SQ_ARM:    if (comp_ceil) st_d = SQ_RAMP;
        SQ_RAMP:   if (at_ceil) st_d = vin_absent ? SQ_HICCUP : SQ_DONE;
        SQ_HICCUP: if (hic_tick) st_d = SQ_RAMP;
        SQ_DONE:   st_d = SQ_DONE;
        default:   st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_seq_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int STEP_CODE = 1,
  parameter int CEIL_CODE = 525,
  parameter int CLK_KHZ   = 10000,
  parameter int RAMP_US   = 2700,
  parameter int HICCUP_US = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              en_above,
  input  logic              comp_ceil,
  input  logic              sw_hi,
  input  logic              hs_first,
  output logic [CODE_W-1:0] ramp_code,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_run,
  output logic              ss_done,
  output logic              pullup_en
);

  localparam int RAMP_STEPS = 100;
  localparam int REF_CODE   = STEP_CODE * RAMP_STEPS;
  localparam int STEP_CYC   = cycles_for(CLK_KHZ, RAMP_US, RAMP_STEPS);
  localparam int HICCUP_CYC = cycles_for(CLK_KHZ, HICCUP_US, 1);

  sq_state_e st;
  logic abort;
  logic in_ramp, in_hic, in_done;
  logic step_tick, hic_tick;
  logic at_ceil, vin_absent, clr_attempt;

  assign abort   = !por_ok || !en_above;
  assign in_ramp = (st == SQ_RAMP);
  assign in_hic  = (st == SQ_HICCUP);
  assign in_done = (st == SQ_DONE);

  // A new attempt (or none) wipes the ramp and the supply-check record.
  assign clr_attempt = abort || (st == SQ_IDLE) || (st == SQ_ARM) || (in_hic && hic_tick);

  ss_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .comp_ceil  (comp_ceil),
    .at_ceil    (at_ceil),
    .vin_absent (vin_absent),
    .hic_tick   (hic_tick),
    .st_q       (st)
  );

  ss_step_timer #(.PERIOD(STEP_CYC)) u_step_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_ramp),
    .tick  (step_tick)
  );

  ss_step_timer #(.PERIOD(HICCUP_CYC)) u_hic_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_hic),
    .tick  (hic_tick)
  );

  ss_ramp_gen #(
    .CODE_W    (CODE_W),
    .STEP_CODE (STEP_CODE),
    .CEIL_CODE (CEIL_CODE),
    .REF_CODE  (REF_CODE)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_attempt),
    .tick      (step_tick),
    .ramp_code (ramp_code),
    .ref_code  (ref_code),
    .at_ceil   (at_ceil)
  );

  ss_vin_check u_vin (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_attempt),
    .arm       (in_ramp),
    .hs_strobe (hs_first),
    .sw_high   (sw_hi),
    .absent    (vin_absent)
  );

  assign pwm_run   = (in_ramp && !vin_absent) || in_done;
  assign ss_done   = in_done;
  assign pullup_en = por_ok && !in_done;

endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
  parameter int CODE_W    = 10,
  parameter int STEP_CODE = 1,
  parameter int CEIL_CODE = 525,
  parameter int REF_CODE  = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_ok,
  input logic              en_above,
  input logic [CODE_W-1:0] ramp_code,
  input logic [CODE_W-1:0] ref_code,
  input logic              pwm_run,
  input logic              ss_done,
  input logic              pullup_en
);

  a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code > $past(ramp_code)) |->
      (({1'b0, ramp_code} == ({1'b0, $past(ramp_code)} + (CODE_W+1)'(STEP_CODE)))
       || (ramp_code == CODE_W'(CEIL_CODE))));

  a_r9_fall_only_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code < $past(ramp_code)) |-> (ramp_code == '0));

  a_r4_ref_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code <= CODE_W'(REF_CODE)) && (ref_code <= ramp_code));

  a_r5_done_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ramp_code == CODE_W'(CEIL_CODE)));

  a_r6_run_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> pwm_run);

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en_above) |=> ((ramp_code == '0) && !pwm_run && !ss_done));

  a_r10_pullup_off_done: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> !pullup_en);

endmodule

bind softstart_seq ss_seq_chk #(
  .CODE_W    (CODE_W),
  .STEP_CODE (STEP_CODE),
  .CEIL_CODE (CEIL_CODE),
  .REF_CODE  (REF_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_ok    (por_ok),
  .en_above  (en_above),
  .ramp_code (ramp_code),
  .ref_code  (ref_code),
  .pwm_run   (pwm_run),
  .ss_done   (ss_done),
  .pullup_en (pullup_en)
);

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 10;
  localparam int STEP = 5;    // 1000 kHz * 500 us / 100000
  localparam int CEIL = 525;
  localparam int REFC = 100;
  localparam int HIC  = 200;  // 1000 kHz * 200 us / 1000
  localparam int TOP_EDGE = CEIL * STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b0, en_above = 1'b0, comp_ceil = 1'b0, sw_hi = 1'b0, hs_first = 1'b0;
  logic [CW-1:0] ramp_code, ref_code;
  logic pwm_run, ss_done, pullup_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_seq #(
    .CODE_W(CW), .STEP_CODE(1), .CEIL_CODE(CEIL),
    .CLK_KHZ(1000), .RAMP_US(500), .HICCUP_US(200)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_above(en_above),
    .comp_ceil(comp_ceil), .sw_hi(sw_hi), .hs_first(hs_first),
    .ramp_code(ramp_code), .ref_code(ref_code), .pwm_run(pwm_run),
    .ss_done(ss_done), .pullup_en(pullup_en)
  );

  // Normal ramp: edge offsets from ramp start and expected outputs (R3, R4, R5, R6).
  localparam int NV = 12;
  localparam int V_OFF [NV] = '{0, 4, 5, 12, 250, 499, 500, 505, 1000, 2620, TOP_EDGE, TOP_EDGE+1};
  localparam int V_RAMP[NV] = '{0, 0, 1, 2, 50, 99, 100, 101, 200, 524, CEIL, CEIL};
  localparam int V_REF [NV] = '{0, 0, 1, 2, 50, 99, 100, 100, 100, 100, REFC, REFC};
  localparam int V_DONE[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int now;
    // R1: reset state
    adv(3);
    chk("R1", "ramp", int'(ramp_code), 0);
    chk("R1", "ref", int'(ref_code), 0);
    chk("R1", "pwm_run", int'(pwm_run), 0);
    chk("R1", "ss_done", int'(ss_done), 0);
    chk("R10", "pullup no por", int'(pullup_en), 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: supply good but no enable
    @(negedge clk) por_ok = 1'b1;
    #1 chk("R10", "pullup with por", int'(pullup_en), 1);
    adv(10);
    chk("R2", "ramp no enable", int'(ramp_code), 0);
    chk("R2", "run no enable", int'(pwm_run), 0);
    // R2: enabled but pin not at ceiling
    @(negedge clk) en_above = 1'b1;
    adv(20);
    chk("R2", "ramp no ceiling", int'(ramp_code), 0);
    chk("R2", "run no ceiling", int'(pwm_run), 0);

    // Main ramp table walk
    @(negedge clk) comp_ceil = 1'b1;
    adv(1);
    now = 0;
    for (int i = 0; i < NV; i++) begin
      if (V_OFF[i] > now) adv(V_OFF[i] - now);
      now = V_OFF[i];
      chk("R3", $sformatf("ramp @%0d", now), int'(ramp_code), V_RAMP[i]);
      chk("R4", $sformatf("ref @%0d", now), int'(ref_code), V_REF[i]);
      chk("R5", $sformatf("done @%0d", now), int'(ss_done), V_DONE[i]);
      chk("R6", $sformatf("run @%0d", now), int'(pwm_run), 1);
    end
    chk("R10", "pullup off when done", int'(pullup_en), 0);

    // R9: enable loss from done
    @(negedge clk) en_above = 1'b0;
    adv(1);
    chk("R9", "ramp after en loss", int'(ramp_code), 0);
    chk("R9", "run after en loss", int'(pwm_run), 0);
    chk("R9", "done after en loss", int'(ss_done), 0);
    chk("R10", "pullup back on", int'(pullup_en), 1);

    // R7/R8: failed supply check and hiccup
    @(negedge clk) en_above = 1'b1;
    adv(2);                      // ramp start, offset 0
    adv(19);
    @(negedge clk) begin hs_first = 1'b1; sw_hi = 1'b0; end
    adv(1);                      // offset 20
    chk("R7", "run after bad check", int'(pwm_run), 0);
    chk("R7", "ramp keeps counting", int'(ramp_code), 4);
    @(negedge clk) hs_first = 1'b0;
    adv(TOP_EDGE - 20);
    chk("R8", "ramp at top", int'(ramp_code), CEIL);
    chk("R8", "no done after bad check", int'(ss_done), 0);
    adv(75);                     // offset TOP_EDGE+75, inside hiccup
    chk("R8", "ramp held in hiccup", int'(ramp_code), CEIL);
    chk("R8", "done low in hiccup", int'(ss_done), 0);
    chk("R8", "run low in hiccup", int'(pwm_run), 0);
    adv(1 + HIC - 75);           // hiccup exit edge
    chk("R8", "ramp restarted", int'(ramp_code), 0);
    chk("R8", "run after restart", int'(pwm_run), 1);

    // R11: passing first strobe, later failing strobe ignored
    adv(9);
    @(negedge clk) begin hs_first = 1'b1; sw_hi = 1'b1; end
    @(negedge clk) begin hs_first = 1'b0; end
    adv(2);
    @(negedge clk) begin hs_first = 1'b1; sw_hi = 1'b0; end
    @(negedge clk) hs_first = 1'b0;
    adv(3);
    chk("R11", "second strobe ignored", int'(pwm_run), 1);
    adv(TOP_EDGE);
    chk("R5", "done with supply present", int'(ss_done), 1);
    chk("R5", "ramp saturated", int'(ramp_code), CEIL);

    // R9: supply loss mid-operation, then restart (R2)
    @(negedge clk) por_ok = 1'b0;
    #1 chk("R10", "pullup follows por", int'(pullup_en), 0);
    adv(1);
    chk("R9", "ramp after por loss", int'(ramp_code), 0);
    chk("R9", "run after por loss", int'(pwm_run), 0);
    chk("R9", "done after por loss", int'(ss_done), 0);
    @(negedge clk) por_ok = 1'b1;
    adv(2);
    chk("R2", "run at restart", int'(pwm_run), 1);
    chk("R2", "ramp at restart", int'(ramp_code), 0);
    adv(STEP);
    chk("R3", "first step after restart", int'(ramp_code), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule